// File: doc/BRIEF.md
# Embedded Timing Reference Decoder

This block watches an 8-bit 4:2:2 component byte stream clocked at the 27 MHz component rate. It finds the embedded timing reference codes that mark the start and the end of each line's active video. From these codes alone it rebuilds active-low horizontal and vertical sync pulses and a field flag, placed on the same clocks as a locally generated master timing would place them. It also produces a qualifier that is high while the delayed payload carries active picture samples. The first active Cb byte of each line carries a one-clock marker.

The payload is delayed by four clocks. A timing code is only recognised once all of its bytes have been seen, and the delay lets the qualifier drop before any code byte reaches the output. The integrator drives an enable, which is set only when the system clock is the 27 MHz component clock, and a line-standard select that picks 525-line or 625-line vertical sync length. Blanking-size settings play no part here: timing comes from the data stream.

Top module: `trs_sync_decoder`

## Requirements
- R1: During and right after synchronous reset, hsync_n and vsync_n are 1, and active, first_cb, field and dout are 0.
- R2: dout repeats din four clock cycles later: a byte driven in cycle n is on dout in cycle n+4, whatever its value.
- R3: A timing code is the byte sequence FF, 00, 00 followed by a flag byte with bit 7 = 1. In the flag byte, bit 6 is the field bit F, bit 5 is the vertical blanking bit V, and bit 4 is H (1 = end of active video, 0 = start of active video). Bits 3:0 have no effect.
- R4: After a start code with V = 0, active rises on the cycle dout carries the first byte after the flag byte (Cb of the Cb, Y, Cr, Y order). first_cb is 1 for exactly that one cycle.
- R5: active falls on the cycle the end code's FF byte reaches dout, and a start code with V = 1 leaves active low.
- R6: hsync_n goes low HS_OFFSET clocks after the clock edge that captures an end code's flag byte and stays low for HS_WIDTH clocks.
- R7: field takes the F bit of the most recent end code two clocks after hsync_n falls, and changes at no other time.
- R8: When an end code has V = 1 and the previous code had V = 0, vsync_n falls together with hsync_n. It stays low for VS_HALF_525 × 858 clocks when std_625 = 0 and for VS_HALF_625 × 864 clocks when std_625 = 1.
- R9: An end code with V = 1 that follows a code with V = 1 does not start a new vsync_n pulse.
- R10: While en = 0, codes are ignored, active and first_cb are 0, and hsync_n and vsync_n are 1.
- R11: A flag byte with bit 7 = 0 after FF, 00, 00 is not a code: it changes neither active nor the sync outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz component-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Decoder enable |
| std_625 | input | 1 | Line standard: 0 = 525 lines, 1 = 625 lines |
| din | input | 8 | 4:2:2 component byte stream with embedded codes |
| dout | output | 8 | Stream delayed by four clocks |
| hsync_n | output | 1 | Regenerated horizontal sync, active low |
| vsync_n | output | 1 | Regenerated vertical sync, active low |
| field | output | 1 | Field flag from the F bit |
| active | output | 1 | High while dout carries active picture bytes |
| first_cb | output | 1 | One-clock marker on the first active Cb byte |

## Verification
The bench builds the block with HS_OFFSET = 4, HS_WIDTH = 10, VS_HALF_525 = 2 and VS_HALF_625 = 1. The short horizontal pulse lets every clock of hsync_n and the field update point be compared one by one. The vertical pulses shrink to 1716 and 864 clocks, so the bench can measure both line standards end to end and can check that no second pulse starts while V stays high. The four-clock data delay and the code byte positions are fixed by the code format, so they are exercised at their real values.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam int CODE_W     = 8;
    localparam int PRE_LEN    = 3;              // FF, 00, 00 before the flag byte
    localparam int PIPE_DEPTH = PRE_LEN + 1;    // data delay in clocks
    localparam int LUMA_525   = 858;            // luma periods per 525-line line
    localparam int LUMA_625   = 864;            // luma periods per 625-line line

    typedef logic [CODE_W-1:0] byte_t;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } trs_flags_t;

    typedef enum logic {
        STD_525 = 1'b0,
        STD_625 = 1'b1
    } line_std_e;

    function automatic int span_clocks(input int half_lines, input int luma_per_line);
        return half_lines * luma_per_line;
    endfunction

endpackage

// File: rtl/trs_detect.sv
module trs_detect
    import trs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  byte_t      din,
    output byte_t      dout,
    output logic       code_vld,
    output trs_flags_t code_flags
);

    byte_t pipe [PIPE_DEPTH];
    logic [PRE_LEN-1:0] pre_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PIPE_DEPTH; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < PIPE_DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    // oldest preamble byte must be all ones, the later ones all zeros
    for (genvar k = 0; k < PRE_LEN; k++) begin : g_pre
        if (k == PRE_LEN - 1) begin : g_ones
            assign pre_match[k] = (pipe[k] == '1);
        end else begin : g_zeros
            assign pre_match[k] = (pipe[k] == '0);
        end
    end

    assign code_vld   = en && (&pre_match) && din[CODE_W-1];
    assign code_flags = '{f: din[6], v: din[5], h: din[4]};
    assign dout       = pipe[PIPE_DEPTH-1];

    // the code's leading FF reaches the output on the edge that captures the flag byte
    p_code_front_out_r3: assert property (@(posedge clk) disable iff (rst)
        code_vld |=> (dout == '1))
        else $error("code front byte not at output");

endmodule

// File: rtl/trs_active_align.sv
module trs_active_align
    import trs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic code_vld,
    input  logic code_h,
    input  logic code_v,
    output logic active,
    output logic first_cb
);

    logic [PIPE_DEPTH-1:0] sav_sr;
    logic sav_open;
    logic eav_seen;

    assign sav_open = code_vld && !code_h && !code_v;
    assign eav_seen = code_vld && code_h;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            sav_sr   <= '0;
            active   <= 1'b0;
            first_cb <= 1'b0;
        end else begin
            sav_sr   <= {sav_sr[PIPE_DEPTH-2:0], sav_open};
            first_cb <= sav_sr[PIPE_DEPTH-1];
            if (eav_seen) begin
                active <= 1'b0;
            end else if (sav_sr[PIPE_DEPTH-1]) begin
                active <= 1'b1;
            end
        end
    end

    p_first_cb_single_r4: assert property (@(posedge clk) disable iff (rst)
        first_cb |=> !first_cb)
        else $error("first_cb longer than one clock");

    p_first_cb_in_active_r4: assert property (@(posedge clk) disable iff (rst)
        first_cb |-> active)
        else $error("first_cb outside active");

    p_eav_closes_r5: assert property (@(posedge clk) disable iff (rst)
        eav_seen |=> !active)
        else $error("active survived end code");

endmodule

// File: rtl/trs_sync_gen.sv
module trs_sync_gen
    import trs_pkg::*;
#(
    parameter int HS_OFFSET   = 4,
    parameter int HS_WIDTH    = 126,
    parameter int VS_HALF_525 = 6,
    parameter int VS_HALF_625 = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       std_625,
    input  logic       code_vld,
    input  trs_flags_t code_flags,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic       field
);

    localparam int HS_END = HS_OFFSET + HS_WIDTH;
    localparam int HCW    = $clog2(HS_END + 2);
    localparam int VS_525 = span_clocks(VS_HALF_525, LUMA_525);
    localparam int VS_625 = span_clocks(VS_HALF_625, LUMA_625);
    localparam int VS_MAX = (VS_525 > VS_625) ? VS_525 : VS_625;
    localparam int VCW    = $clog2(HS_OFFSET + VS_MAX + 2);

    localparam logic [HCW-1:0] H_START   = HCW'(HS_OFFSET);
    localparam logic [HCW-1:0] H_STOP    = HCW'(HS_END);
    localparam logic [HCW-1:0] H_FIELD   = HCW'(HS_OFFSET + 2);
    localparam logic [VCW-1:0] V_START   = VCW'(HS_OFFSET);
    localparam logic [VCW-1:0] V_END_525 = VCW'(HS_OFFSET + VS_525);
    localparam logic [VCW-1:0] V_END_625 = VCW'(HS_OFFSET + VS_625);

    logic [HCW-1:0] hcnt;
    logic [VCW-1:0] vcnt;
    logic [VCW-1:0] vs_end;
    logic           v_prev;
    logic           f_latch;
    logic           eav;
    logic           v_rise;
    line_std_e      std_sel;

    assign std_sel = line_std_e'(std_625);
    assign eav     = code_vld && code_flags.h;
    assign v_rise  = eav && code_flags.v && !v_prev;

    // horizontal counter: clocks since the last end code, parks past the pulse
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hcnt <= '0;
        end else if (eav) begin
            hcnt <= HCW'(1);
        end else if (hcnt != '0 && hcnt <= H_STOP) begin
            hcnt <= hcnt + HCW'(1);
        end
    end

    // vertical counter: started only on the V rising edge of a field start
    always_ff @(posedge clk) begin
        if (rst || !en) begin
            vcnt   <= '0;
            vs_end <= V_END_525;
        end else if (v_rise) begin
            vcnt   <= VCW'(1);
            vs_end <= (std_sel == STD_625) ? V_END_625 : V_END_525;
        end else if (vcnt != '0 && vcnt <= vs_end) begin
            vcnt <= vcnt + VCW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_prev  <= 1'b0;
            f_latch <= 1'b0;
            field   <= 1'b0;
        end else if (en) begin
            if (code_vld) v_prev <= code_flags.v;
            if (eav) f_latch <= code_flags.f;
            if (hcnt == H_FIELD) field <= f_latch;
        end
    end

    assign hsync_n = !(hcnt > H_START && hcnt <= H_STOP);
    assign vsync_n = !(vcnt > V_START && vcnt <= vs_end);

    p_hs_idle_off_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (hsync_n && vsync_n))
        else $error("sync active while disabled");

    p_field_in_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(field) |-> !hsync_n)
        else $error("field moved outside hsync pulse");

    p_hs_high_after_eav_r6: assert property (@(posedge clk) disable iff (rst)
        eav |=> hsync_n)
        else $error("hsync low right after end code");

endmodule

// File: rtl/trs_sync_decoder.sv
module trs_sync_decoder
    import trs_pkg::*;
#(
    parameter int HS_OFFSET   = 4,
    parameter int HS_WIDTH    = 126,
    parameter int VS_HALF_525 = 6,
    parameter int VS_HALF_625 = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       std_625,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic       field,
    output logic       active,
    output logic       first_cb
);

    logic       code_vld;
    trs_flags_t code_flags;

    trs_detect u_detect (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .din        (din),
        .dout       (dout),
        .code_vld   (code_vld),
        .code_flags (code_flags)
    );

    trs_active_align u_align (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .code_vld (code_vld),
        .code_h   (code_flags.h),
        .code_v   (code_flags.v),
        .active   (active),
        .first_cb (first_cb)
    );

    trs_sync_gen #(
        .HS_OFFSET   (HS_OFFSET),
        .HS_WIDTH    (HS_WIDTH),
        .VS_HALF_525 (VS_HALF_525),
        .VS_HALF_625 (VS_HALF_625)
    ) u_sync (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .std_625    (std_625),
        .code_vld   (code_vld),
        .code_flags (code_flags),
        .hsync_n    (hsync_n),
        .vsync_n    (vsync_n),
        .field      (field)
    );

    p_rise_marks_cb_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> first_cb)
        else $error("active rose without Cb marker");

    p_off_when_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!active && !first_cb))
        else $error("active while disabled");

endmodule

// File: tb/trs_sync_decoder_test.sv
module trs_sync_decoder_test;

    localparam int HS_OFFSET   = 4;
    localparam int HS_WIDTH    = 10;
    localparam int VS_HALF_525 = 2;
    localparam int VS_HALF_625 = 1;
    localparam int VS_525      = VS_HALF_525 * 858;
    localparam int VS_625      = VS_HALF_625 * 864;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b1;
    logic       std_625 = 1'b0;
    logic [7:0] din = 8'h10;
    logic [7:0] dout;
    logic       hsync_n, vsync_n, field, active, first_cb;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    trs_sync_decoder #(
        .HS_OFFSET   (HS_OFFSET),
        .HS_WIDTH    (HS_WIDTH),
        .VS_HALF_525 (VS_HALF_525),
        .VS_HALF_625 (VS_HALF_625)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .std_625  (std_625),
        .din      (din),
        .dout     (dout),
        .hsync_n  (hsync_n),
        .vsync_n  (vsync_n),
        .field    (field),
        .active   (active),
        .first_cb (first_cb)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive a byte at a falling edge; returns after the next rising edge has captured it
    task automatic step(input logic [7:0] b);
        din = b;
        @(negedge clk);
    endtask

    task automatic send_code(input bit f, input bit v, input bit h, input logic [3:0] prot);
        step(8'hFF);
        step(8'h00);
        step(8'h00);
        step({1'b1, f, v, h, prot});
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) step(8'h10);
        check("R1 hsync_n", hsync_n, 1);
        check("R1 vsync_n", vsync_n, 1);
        check("R1 active", active, 0);
        check("R1 first_cb", first_cb, 0);
        check("R1 field", field, 0);
        check("R1 dout", dout, 0);
        rst = 1'b0;
    endtask

    task automatic test_delay();
        logic [7:0] hist [8];
        for (int i = 0; i < 8; i++) begin
            hist[i] = 8'h21 + 8'(i * 17);
            step(hist[i]);
            if (i >= 3) check("R2 dout delay", dout, hist[i-3]);
        end
    endtask

    task automatic test_line();
        send_code(1'b0, 1'b0, 1'b0, 4'hA);      // start of active, protection bits set
        check("R4 active at code", active, 0);
        step(8'h55); step(8'h66); step(8'h77);
        check("R4 active before Cb", active, 0);
        step(8'h88);
        check("R4 active on Cb", active, 1);
        check("R4 first_cb on Cb", first_cb, 1);
        check("R4 dout Cb", dout, 8'h55);
        step(8'h99);
        check("R4 active on Y", active, 1);
        check("R4 first_cb one clock", first_cb, 0);
        check("R2 dout Y", dout, 8'h66);
        step(8'hAA); step(8'hBB);
        step(8'hFF); step(8'h00); step(8'h00);
        check("R5 active until code reaches out", active, 1);
        step(8'h95);                            // end code, F=0 V=0, protection bits 5
        check("R5 active off at FF", active, 0);
        check("R5 dout FF", dout, 8'hFF);
        check("R3 protection ignored hsync idle", hsync_n, 1);
        for (int k = 1; k <= HS_WIDTH + HS_OFFSET + 4; k++) begin
            step(8'h10);
            check("R6 hsync_n timing", hsync_n,
                  (k >= HS_OFFSET && k < HS_OFFSET + HS_WIDTH) ? 0 : 1);
        end
        check("R7 field unchanged F=0", field, 0);
    endtask

    task automatic test_field();
        send_code(1'b1, 1'b0, 1'b1, 4'h3);
        for (int k = 1; k <= 12; k++) begin
            step(8'h10);
            check("R7 field timing", field, (k >= HS_OFFSET + 2) ? 1 : 0);
        end
    endtask

    task automatic test_blank_sav();
        send_code(1'b0, 1'b1, 1'b0, 4'h0);      // start code in vertical blanking
        for (int k = 1; k <= 6; k++) begin
            step(8'h40);
            check("R5 active stays low V=1", active, 0);
            check("R4 first_cb low V=1", first_cb, 0);
        end
    endtask

    task automatic vs_window(input string tag, input int len);
        for (int k = 1; k <= HS_OFFSET + len + 2; k++) begin
            step(8'h10);
            if (k == HS_OFFSET - 1 || k == HS_OFFSET || k == HS_OFFSET + len - 1 ||
                k == HS_OFFSET + len || k == HS_OFFSET + len / 2)
                check(tag, vsync_n, (k >= HS_OFFSET && k < HS_OFFSET + len) ? 0 : 1);
            if (k == HS_OFFSET)
                check("R8 vsync with hsync", hsync_n, 0);
        end
    endtask

    task automatic test_vsync();
        std_625 = 1'b0;
        send_code(1'b0, 1'b0, 1'b1, 4'h0);
        repeat (20) step(8'h10);
        send_code(1'b0, 1'b1, 1'b1, 4'h0);
        vs_window("R8 vsync_n 525", VS_525);
        send_code(1'b0, 1'b1, 1'b1, 4'h0);      // V stays 1
        for (int k = 1; k <= 14; k++) begin
            step(8'h10);
            check("R9 no retrigger", vsync_n, 1);
        end
        std_625 = 1'b1;
        send_code(1'b1, 1'b0, 1'b1, 4'h0);
        repeat (20) step(8'h10);
        send_code(1'b1, 1'b1, 1'b1, 4'h0);
        vs_window("R8 vsync_n 625", VS_625);
    endtask

    task automatic test_bad_marker();
        send_code(1'b0, 1'b0, 1'b0, 4'h0);
        repeat (6) step(8'h60);
        check("R11 active set up", active, 1);
        step(8'hFF); step(8'h00); step(8'h00); step(8'h10);   // bit 7 clear
        for (int k = 1; k <= HS_OFFSET + HS_WIDTH + 2; k++) begin
            step(8'h61);
            check("R11 hsync unchanged", hsync_n, 1);
            check("R11 active unchanged", active, 1);
        end
    endtask

    task automatic test_disable();
        en = 1'b0;
        step(8'h20);
        check("R10 active drops", active, 0);
        send_code(1'b0, 1'b1, 1'b1, 4'h0);
        for (int k = 1; k <= HS_OFFSET + HS_WIDTH + 2; k++) begin
            step(8'h10);
            check("R10 hsync_n idle", hsync_n, 1);
            check("R10 vsync_n idle", vsync_n, 1);
        end
        send_code(1'b0, 1'b0, 1'b0, 4'h0);
        for (int k = 1; k <= 6; k++) begin
            step(8'h30);
            check("R10 active idle", active, 0);
            check("R10 first_cb idle", first_cb, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        test_reset();
        test_delay();
        test_line();
        test_field();
        test_blank_sav();
        test_vsync();
        test_bad_marker();
        test_disable();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule